// File: doc/BRIEF.md
# Serial Memory Page-Program Command Engine

This block is the slave-side command logic of a small serial memory. A host frames each command by pulling chip select low. It then clocks an 8-bit opcode and any operand bytes into the single data input, most significant bit first. The host samples input on the rising serial-clock edge, and the block drives its reply on the falling edge. The serial clock, chip select and data input are sampled by the much faster system clock, and edges are detected in that domain.

Three commands are decoded: write enable, page program and read status. A page program carries a 24-bit address and one or more data bytes. These bytes fill a 64-byte page buffer, which wraps within the page. A per-byte mask records which offsets were written. When chip select rises exactly on a byte boundary, a self-timed busy period starts. During that period the masked bytes are copied into the on-chip array, and bytes that were not written are left alone. The array's contents stay readable by neighbouring logic through a plain asynchronous read port.

Top module: `spi_page_prog`

## Requirements
- R1: After reset the status byte reads 00h, the serial output is 0 and every array byte holds FFh.
- R2: Opcode 06h, when the block is not busy, sets the write-enable flag, which is bit 1 of the status byte.
- R3: Opcode 02h (page program) while the write-enable flag is 0 is ignored, and the array does not change.
- R4: A page program writes each received byte at the address's page offset and following offsets. Other bytes of the page keep their values, and the write-enable flag reads 0 from the second busy cycle on.
- R5: Bytes that pass offset 63 continue at offset 0 of the same page, and the upper address bits stay fixed.
- R6: When more than 64 data bytes are sent, each offset ends up holding the last byte that was sent to it, so only the final 64 bytes count.
- R7: If chip select rises while a data byte is incomplete, nothing is written, no busy period starts and the write-enable flag is kept.
- R8: The busy flag, which is status bit 0, reads 1 for TPP system cycles after a committing chip-select rise, and 0 afterwards.
- R9: While busy, every opcode other than 05h is ignored. A write enable sent during busy leaves the flag at 0, and a page program sent during busy changes no byte.
- R10: Opcode 05h returns the status byte MSB first, driven on falling serial-clock edges. The byte repeats for as long as chip select stays low, and the output is 0 whenever chip select is high.
- R11: An unrecognised opcode causes the remainder of that frame to be ignored, including a valid opcode that follows it.
- R12: A page program whose frame ends right after the three address bytes writes nothing and starts no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock (mode 0) |
| cs_n | input | 1 | Active-low chip select framing a command |
| sdi | input | 1 | Serial data input, MSB first |
| sdo | output | 1 | Serial status output, changes after sclk falls |
| rd_addr | input | $clog2(MEM_BYTES) | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The assertions rely on the serial clock being slow against the system clock, with each serial phase spanning several system cycles. They also rely on chip select changing only while the serial clock is low, so that no edge is lost and a busy period can only begin when chip select rises. The bench keeps every serial half period at four system cycles and moves chip select only with the serial clock low. It also sets TPP longer than any status read or ignored frame it issues inside a busy period, so busy-time behaviour is observed while the flag is still set.

// File: rtl/spi_page_prog.sv
module spi_page_prog #(
  parameter int MEM_BYTES = 256,
  parameter int TPP = 400,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int TPP_EFF = (TPP < 64) ? 64 : TPP;
  localparam int CW = $clog2(TPP_EFF) + 1;
  localparam logic [7:0] OP_WEN = 8'h06, OP_PROG = 8'h02, OP_STAT = 8'h05;

  typedef enum logic [2:0] {S_OP, S_ADDR, S_DATA, S_STAT, S_IGN} st_t;
  st_t st;

  logic sclk_s, sclk_d, cs_s, cs_d, sdi_s;
  logic [4:0]  cnt;
  logic [7:0]  shreg, osh;
  logic [2:0]  ocnt;
  logic [23:0] addr;
  logic [5:0]  ofs;
  logic [63:0] mask;
  logic        got, wel, busy;
  logic [CW-1:0] bcnt;
  logic [7:0]  pbuf [64];
  logic [7:0]  mem [MEM_BYTES];

  wire rise  = ~cs_s & sclk_s & ~sclk_d;
  wire fall  = ~cs_s & ~sclk_s & sclk_d;
  wire cs_up = cs_s & ~cs_d;
  wire [7:0] nb = {shreg[6:0], sdi_s};
  wire [7:0] stat = {6'b0, wel, busy};
  wire start = cs_up && st == S_DATA && cnt == 5'd0 && got && !busy;
  wire mem_we = busy && bcnt < CW'(64) && mask[bcnt[5:0]];
  wire [AW-1:0] wr_idx = {addr[AW-1:6], bcnt[5:0]};

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 1'b0; sclk_d <= 1'b0; cs_s <= 1'b1; cs_d <= 1'b1; sdi_s <= 1'b0;
      st <= S_OP; cnt <= '0; shreg <= '0; osh <= '0; ocnt <= '0;
      addr <= '0; ofs <= '0; mask <= '0; got <= 1'b0;
      wel <= 1'b0; busy <= 1'b0; bcnt <= '0; sdo <= 1'b0;
    end else begin
      sclk_s <= sclk; sclk_d <= sclk_s; cs_s <= cs_n; cs_d <= cs_s; sdi_s <= sdi;

      if (start) begin
        busy <= 1'b1;
        bcnt <= '0;
      end else if (busy) begin
        bcnt <= bcnt + 1'b1;
        if (bcnt == CW'(TPP_EFF - 1)) busy <= 1'b0;
      end

      if (busy && bcnt == '0) wel <= 1'b0;
      else if (rise && st == S_OP && cnt == 5'd7 && nb == OP_WEN && !busy) wel <= 1'b1;

      if (cs_s) sdo <= 1'b0;

      if (cs_up) begin
        st <= S_OP;
        cnt <= '0;
      end else if (rise) begin
        shreg <= nb;
        case (st)
          S_OP: begin
            cnt <= cnt + 1'b1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (nb == OP_STAT) begin
                st <= S_STAT;
                ocnt <= '0;
              end else if (nb == OP_PROG && wel && !busy) begin
                st <= S_ADDR;
                mask <= '0;
                got <= 1'b0;
              end else begin
                st <= S_IGN;
              end
            end
          end
          S_ADDR: begin
            addr <= {addr[22:0], sdi_s};
            cnt <= cnt + 1'b1;
            if (cnt == 5'd23) begin
              st <= S_DATA;
              cnt <= '0;
              ofs <= {addr[4:0], sdi_s};
            end
          end
          S_DATA: begin
            cnt <= (cnt == 5'd7) ? 5'd0 : cnt + 1'b1;
            if (cnt == 5'd7) begin
              mask[ofs] <= 1'b1;
              ofs <= ofs + 1'b1;
              got <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fall && st == S_STAT) begin
        ocnt <= ocnt + 1'b1;
        if (ocnt == 3'd0) begin
          sdo <= stat[7];
          osh <= {stat[6:0], 1'b0};
        end else begin
          sdo <= osh[7];
          osh <= {osh[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (rise && st == S_DATA && cnt == 5'd7) pbuf[ofs] <= nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (mem_we) begin
      mem[wr_idx] <= pbuf[bcnt[5:0]];
    end
  end

  // R4
  wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !wel);
  // R3
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R7
  cs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_s));
  // R10
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s && $past(cs_s) |-> !sdo);
  // R9
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> st != S_ADDR);
endmodule

// File: tb/spi_page_prog_tb.sv
module spi_page_prog_tb;
  localparam int MB = 256;
  localparam int TP = 600;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] exp_mem [MB];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_page_prog #(.MEM_BYTES(MB), .TPP(TP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b; wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(4); v[i] = sdo; sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
  endtask

  task automatic cs_lo; cs_n = 1'b0; wait_clk(4); endtask
  task automatic cs_hi; wait_clk(4); cs_n = 1'b1; wait_clk(6); endtask

  task automatic get_status(output logic [7:0] s);
    cs_lo; send_byte(8'h05); read_byte(s); cs_hi;
  endtask

  task automatic wren; cs_lo; send_byte(8'h06); cs_hi; endtask

  task automatic prog_hdr(input logic [23:0] a);
    send_byte(8'h02); send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask

  task automatic model_write(input logic [23:0] a, input int n, input int seed);
    for (int i = 0; i < n; i++)
      exp_mem[{a[7:6], 6'(a[5:0] + i)}] = 8'(seed + i * 7);
  endtask

  task automatic prog(input logic [23:0] a, input int n, input int seed);
    cs_lo; prog_hdr(a);
    for (int i = 0; i < n; i++) send_byte(8'(seed + i * 7));
    cs_hi;
  endtask

  task automatic compare_mem(input string req);
    int miss = 0, first = -1;
    for (int i = 0; i < MB; i++) begin
      rd_addr = 8'(i); #1;
      if (rd_data !== exp_mem[i]) begin
        miss++;
        if (first < 0) first = i;
      end
    end
    total++;
    if (miss != 0) begin
      bad++;
      rd_addr = 8'(first); #1;
      $display("FAIL %s: addr %0h actual=%0h expected=%0h (%0d bytes differ)",
               req, first, rd_data, exp_mem[first], miss);
    end
  endtask

  task automatic t_reset;
    logic [7:0] s;
    check("R1 sdo", int'(sdo), 0);
    get_status(s);
    check("R1 status", s, 8'h00);
    compare_mem("R1 array");
  endtask

  task automatic t_unknown;
    logic [7:0] s;
    cs_lo; send_byte(8'hAA); send_byte(8'h06); cs_hi;
    get_status(s);
    check("R11 wel after unknown opcode", s, 8'h00);
  endtask

  task automatic t_nowel;
    prog(24'h000010, 2, 8'h11);
    wait_clk(TP + 20);
    compare_mem("R3 no write without wel");
  endtask

  task automatic t_wren;
    logic [7:0] s1, s2;
    wren;
    cs_lo; send_byte(8'h05); read_byte(s1); read_byte(s2); cs_hi;
    check("R2 wel set", s1, 8'h02);
    check("R10 status repeats", s2, 8'h02);
  endtask

  task automatic t_basic;
    logic [7:0] s;
    prog(24'h000045, 3, 8'h30);
    model_write(24'h000045, 3, 8'h30);
    get_status(s);
    check("R8 wip during program, R4 wel clear", s, 8'h01);
    wait_clk(TP);
    get_status(s);
    check("R8 wip after program", s, 8'h00);
    compare_mem("R4 addressed bytes");
  endtask

  task automatic t_wrap;
    wren;
    prog(24'hFF007E, 4, 8'h50);
    model_write(24'h00007E, 4, 8'h50);
    wait_clk(TP + 20);
    compare_mem("R5 wrap in page");
  endtask

  task automatic t_over;
    wren;
    prog(24'h000080, 70, 8'h01);
    model_write(24'h000080, 70, 8'h01);
    wait_clk(TP + 20);
    compare_mem("R6 last 64 bytes");
  endtask

  task automatic t_partial;
    logic [7:0] s;
    wren;
    cs_lo; prog_hdr(24'h0000C0); send_byte(8'h99); send_byte(8'h98);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); cs_hi;
    get_status(s);
    check("R7 no busy, wel kept", s, 8'h02);
    compare_mem("R7 array untouched");
  endtask

  task automatic t_nodata;
    logic [7:0] s;
    cs_lo; prog_hdr(24'h0000C4); cs_hi;
    get_status(s);
    check("R12 no busy, wel kept", s, 8'h02);
    compare_mem("R12 array untouched");
  endtask

  task automatic t_busy;
    logic [7:0] s;
    prog(24'h0000D0, 2, 8'h70);
    model_write(24'h0000D0, 2, 8'h70);
    wren;
    prog(24'h0000E0, 2, 8'h20);
    get_status(s);
    check("R9 status honoured while busy", s, 8'h01);
    wait_clk(TP + 20);
    get_status(s);
    check("R9 wren ignored while busy", s, 8'h00);
    compare_mem("R9 program ignored while busy");
  endtask

  initial begin
    for (int i = 0; i < MB; i++) exp_mem[i] = 8'hFF;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_unknown;
    t_nowel;
    t_wren;
    t_basic;
    t_wrap;
    t_over;
    t_partial;
    t_nodata;
    t_busy;
    check("R10 sdo idle", int'(sdo), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule